// File: doc/BRIEF.md
# PLL Lock Qualifier and Stability Timer

This block decides when a system-clock PLL may be trusted. It watches the phase detector's "in phase" verdict, one per comparison, and reports lock only after an uninterrupted run of in-phase verdicts. The run length is chosen from four thresholds. A single out-of-phase verdict ends the run and drops lock.

A millisecond timebase is derived from the system clock itself. The clock period, programmed in femtoseconds, is added up on every cycle. Each time the sum crosses one millisecond, a tick is produced and the excess is kept. A programmable stability interval, counted in these ticks, then raises a stable flag. When the PLL is enabled, the interval starts from lock. When the PLL is bypassed, it starts at once. A zero interval means the block is stable straight away.

A calibrate control is also handled. Setting the bit and then clearing it issues a one-cycle calibration request. A busy flag follows the request until the calibration engine reports done. While that flag is up, lock qualification is held off.

Top module: `pll_stab_mon`

## Requirements
- R1: `pll_locked` rises on the clock edge that samples the N-th consecutive `pd_valid` cycle with `pd_in_phase` high, where N is the selected threshold. Cycles with `pd_valid` low neither extend nor break the run.
- R2: A cycle with `pd_valid` high and `pd_in_phase` low clears the run. `pll_locked` is low after that edge.
- R3: `lock_sel` picks the threshold N = LOCK_BASE shifted left by `lock_sel`. With the default LOCK_BASE of 128, the values 0, 1, 2 and 3 give 128, 256, 512 and 1024.
- R4: While `lock_det_dis` is 1, the run is cleared and `pll_locked` is low from the next edge. A value of 0 enables detection.
- R5: Each clock adds `period_fs` to an accumulator. When the sum reaches TICK_FS (10^12 by default), `ms_tick` is high for the next cycle and TICK_FS is subtracted from the sum. Otherwise `ms_tick` is low.
- R6: While `stab_ms` is 0, `stable` is high from the next edge on, regardless of PLL or lock state.
- R7: With `pll_en` at 1 and `stab_ms` nonzero, ticks are counted only while `pll_locked` is high. `stable` rises on the edge that samples the `stab_ms`-th counted tick.
- R8: With `pll_en` at 0 and `stab_ms` nonzero, ticks are counted whatever the lock state, starting as soon as the PLL is disabled.
- R9: With `pll_en` at 1 and `stab_ms` nonzero, a low `pll_locked` clears the tick count and `stable` on the next edge. Counting restarts at the next lock.
- R10: A change of `pll_en` or of a nonzero `stab_ms` clears the count and `stable` on the next edge.
- R11: When an edge samples `cal_bit` low after the previous edge sampled it high, `cal_req` is high for exactly one cycle and `cal_busy` goes high with it. `cal_busy` falls on the edge after `cal_done` is sampled high, unless a new request starts on that edge, which takes priority.
- R12: While `cal_busy` is high, the run is cleared and `pll_locked` is low from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_valid | input | 1 | A phase comparison verdict is present this cycle |
| pd_in_phase | input | 1 | Verdict: 1 in phase, 0 out of phase |
| lock_det_dis | input | 1 | 1 disables the lock detector |
| lock_sel | input | 2 | Lock threshold select |
| pll_en | input | 1 | 1 when the PLL is in use, 0 when bypassed |
| stab_ms | input | 20 | Stability interval in milliseconds |
| period_fs | input | 21 | Nominal clock period in femtoseconds |
| cal_bit | input | 1 | Calibrate control bit |
| cal_done | input | 1 | Calibration finished strobe |
| pll_locked | output | 1 | Lock qualified |
| ms_tick | output | 1 | One-cycle millisecond tick |
| stable | output | 1 | Stability interval expired |
| cal_req | output | 1 | One-cycle calibration request |
| cal_busy | output | 1 | Calibration in progress |

## Verification
Several properties are checked on every cycle:
- an out-of-phase verdict, a disabled detector or a busy calibration always leaves lock low on the next cycle;
- a zero interval always gives stable;
- stable never rises except after a tick;
- an unlocked, enabled PLL or a changed interval always drops stable;
- the calibration request is a single-cycle pulse that coincides with busy.

The exact cycle on which lock appears for each threshold, the remainder carry of the millisecond timebase, and the tick count at which stable rises can only be shown by the bench's scenarios. The same holds for restarts across random enable and interval changes. The bench drives these scenarios against a cycle model of the requirements.

// File: rtl/pll_stab_pkg.sv
package pll_stab_pkg;
   localparam int unsigned SEL_W = 2;
   localparam int unsigned NSEL  = 1 << SEL_W;
   typedef logic [SEL_W-1:0] lock_sel_t;
endpackage

// File: rtl/psm_lock_det.sv
module psm_lock_det
   import pll_stab_pkg::*;
#(
   parameter int unsigned LOCK_BASE = 128
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pd_valid,
   input  logic      pd_in_phase,
   input  logic      det_dis,
   input  logic      hold,
   input  lock_sel_t lock_sel,
   output logic      locked
);
   localparam int unsigned MAX_THR = LOCK_BASE << (NSEL - 1);
   localparam int unsigned CNT_W   = $clog2(MAX_THR + 1);

   logic [CNT_W-1:0] thr_tab [NSEL];
   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] run_inc;
   logic [CNT_W-1:0] thr;

   for (genvar g = 0; g < NSEL; g++) begin : g_thr
      assign thr_tab[g] = CNT_W'(LOCK_BASE << g);
   end

   assign thr     = thr_tab[lock_sel];
   assign run_inc = run_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= '0;
         locked <= 1'b0;
      end else if (det_dis || hold) begin
         run_q  <= '0;
         locked <= 1'b0;
      end else if (pd_valid) begin
         if (!pd_in_phase) begin
            run_q  <= '0;
            locked <= 1'b0;
         end else if (run_inc >= thr) begin
            locked <= 1'b1;
         end else begin
            run_q <= run_inc;
         end
      end
   end
endmodule

// File: rtl/psm_ms_base.sv
module psm_ms_base #(
   parameter longint unsigned TICK_FS = 64'd1_000_000_000_000,
   parameter int unsigned     PER_W   = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PER_W-1:0] period_fs,
   output logic             ms_tick
);
   localparam int unsigned TW    = $clog2(TICK_FS) + 1;
   localparam int unsigned ACC_W = (TW > PER_W + 1) ? TW : PER_W + 1;
   localparam logic [ACC_W-1:0] TICK_V = ACC_W'(TICK_FS);

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] sum;

   assign sum = acc_q + ACC_W'(period_fs);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q   <= '0;
         ms_tick <= 1'b0;
      end else if (sum >= TICK_V) begin
         acc_q   <= sum - TICK_V;
         ms_tick <= 1'b1;
      end else begin
         acc_q   <= sum;
         ms_tick <= 1'b0;
      end
   end
endmodule

// File: rtl/psm_stab_timer.sv
module psm_stab_timer #(
   parameter int unsigned TMR_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_tick,
   input  logic             pll_en,
   input  logic             locked,
   input  logic [TMR_W-1:0] stab_ms,
   output logic             stable
);
   logic [TMR_W-1:0] cnt_q;
   logic [TMR_W-1:0] cnt_inc;
   logic [TMR_W-1:0] ms_q;
   logic             en_q;
   logic             restart;
   logic             running;
   logic             zero_val;

   assign zero_val = (stab_ms == '0);
   assign restart  = (pll_en != en_q) || (stab_ms != ms_q);
   assign running  = pll_en ? locked : 1'b1;
   assign cnt_inc  = cnt_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         ms_q   <= '0;
         en_q   <= 1'b0;
         stable <= 1'b0;
      end else begin
         en_q <= pll_en;
         ms_q <= stab_ms;
         if (zero_val) begin
            stable <= 1'b1;
            cnt_q  <= '0;
         end else if (restart || !running) begin
            stable <= 1'b0;
            cnt_q  <= '0;
         end else if (!stable && ms_tick) begin
            cnt_q <= cnt_inc;
            if (cnt_inc == stab_ms) begin
               stable <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/psm_cal_ctl.sv
module psm_cal_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic cal_bit,
   input  logic cal_done,
   output logic cal_req,
   output logic cal_busy
);
   logic cal_q;
   logic fall;

   assign fall = cal_q && !cal_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cal_q    <= 1'b0;
         cal_req  <= 1'b0;
         cal_busy <= 1'b0;
      end else begin
         cal_q   <= cal_bit;
         cal_req <= fall;
         if (fall) begin
            cal_busy <= 1'b1;
         end else if (cal_done) begin
            cal_busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pll_stab_mon.sv
module pll_stab_mon
   import pll_stab_pkg::*;
#(
   parameter int unsigned     LOCK_BASE = 128,
   parameter longint unsigned TICK_FS   = 64'd1_000_000_000_000,
   parameter int unsigned     PER_W     = 21,
   parameter int unsigned     TMR_W     = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pd_valid,
   input  logic             pd_in_phase,
   input  logic             lock_det_dis,
   input  logic [SEL_W-1:0] lock_sel,
   input  logic             pll_en,
   input  logic [TMR_W-1:0] stab_ms,
   input  logic [PER_W-1:0] period_fs,
   input  logic             cal_bit,
   input  logic             cal_done,
   output logic             pll_locked,
   output logic             ms_tick,
   output logic             stable,
   output logic             cal_req,
   output logic             cal_busy
);
   if (LOCK_BASE == 0) begin : g_bad_base
      $error("LOCK_BASE must be nonzero");
   end
   if (TICK_FS < 2) begin : g_bad_tick
      $error("TICK_FS must be at least 2");
   end
   if (TMR_W == 0 || PER_W == 0) begin : g_bad_width
      $error("TMR_W and PER_W must be nonzero");
   end

   psm_cal_ctl u_cal (
      .clk      (clk),
      .rst_n    (rst_n),
      .cal_bit  (cal_bit),
      .cal_done (cal_done),
      .cal_req  (cal_req),
      .cal_busy (cal_busy)
   );

   psm_lock_det #(.LOCK_BASE(LOCK_BASE)) u_lock (
      .clk         (clk),
      .rst_n       (rst_n),
      .pd_valid    (pd_valid),
      .pd_in_phase (pd_in_phase),
      .det_dis     (lock_det_dis),
      .hold        (cal_busy),
      .lock_sel    (lock_sel),
      .locked      (pll_locked)
   );

   psm_ms_base #(.TICK_FS(TICK_FS), .PER_W(PER_W)) u_ms (
      .clk       (clk),
      .rst_n     (rst_n),
      .period_fs (period_fs),
      .ms_tick   (ms_tick)
   );

   psm_stab_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ms_tick (ms_tick),
      .pll_en  (pll_en),
      .locked  (pll_locked),
      .stab_ms (stab_ms),
      .stable  (stable)
   );
endmodule

// File: rtl/psm_checker.sv
module psm_checker #(
   parameter int unsigned TMR_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pd_valid,
   input logic             pd_in_phase,
   input logic             lock_det_dis,
   input logic             pll_en,
   input logic [TMR_W-1:0] stab_ms,
   input logic             ms_tick,
   input logic             pll_locked,
   input logic             stable,
   input logic             cal_req,
   input logic             cal_busy
);
   assert_lock_after_inphase_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_locked) |-> $past(pd_valid && pd_in_phase));

   assert_outphase_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_valid && !pd_in_phase) |=> !pll_locked);

   assert_det_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lock_det_dis |=> !pll_locked);

   assert_zero_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stab_ms == '0) |=> stable);

   assert_stable_after_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stable) |-> ($past(ms_tick) || ($past(stab_ms) == '0)));

   assert_unlock_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_en && !pll_locked && stab_ms != '0) |=> !stable);

   assert_change_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stab_ms != '0 && !$stable(stab_ms)) |=> !stable);

   assert_req_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cal_req |=> !cal_req);

   assert_req_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cal_req |-> cal_busy);

   assert_busy_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cal_busy |=> !pll_locked);
endmodule

bind pll_stab_mon psm_checker #(.TMR_W(TMR_W)) u_psm_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .pd_valid     (pd_valid),
   .pd_in_phase  (pd_in_phase),
   .lock_det_dis (lock_det_dis),
   .pll_en       (pll_en),
   .stab_ms      (stab_ms),
   .ms_tick      (ms_tick),
   .pll_locked   (pll_locked),
   .stable       (stable),
   .cal_req      (cal_req),
   .cal_busy     (cal_busy)
);

// File: tb/pll_stab_mon_bench.sv
`timescale 1ns/1ps
module pll_stab_mon_bench;
   localparam longint unsigned TB_TICK = 1000;
   localparam int unsigned     TB_BASE = 128;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        pd_valid, pd_in_phase, lock_det_dis, pll_en, cal_bit, cal_done;
   logic [1:0]  lock_sel;
   logic [19:0] stab_ms;
   logic [20:0] period_fs;
   logic        pll_locked, ms_tick, stable, cal_req, cal_busy;

   always #2 clk = ~clk;

   pll_stab_mon #(.LOCK_BASE(TB_BASE), .TICK_FS(TB_TICK)) u_pll_stab_mon (
      .clk(clk), .rst_n(rst_n), .pd_valid(pd_valid), .pd_in_phase(pd_in_phase),
      .lock_det_dis(lock_det_dis), .lock_sel(lock_sel), .pll_en(pll_en),
      .stab_ms(stab_ms), .period_fs(period_fs), .cal_bit(cal_bit), .cal_done(cal_done),
      .pll_locked(pll_locked), .ms_tick(ms_tick), .stable(stable),
      .cal_req(cal_req), .cal_busy(cal_busy));

   int  n_chk  = 0;
   int  n_fail = 0;
   int  cyc    = 0;
   bit  done   = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int thr_of(input logic [1:0] s);
      return int'(TB_BASE) << s;
   endfunction

   // Cycle model written from the requirements
   int     m_run, m_cnt;
   longint m_acc;
   bit     m_lock, m_tick, m_stab, m_enq, m_calq, m_req, m_busy;
   logic [19:0] m_msq;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run <= 0; m_lock <= 0; m_acc <= 0; m_tick <= 0;
         m_cnt <= 0; m_stab <= 0; m_enq <= 0; m_msq <= '0;
         m_calq <= 0; m_req <= 0; m_busy <= 0;
      end else begin
         // R1 R2 R3 R4 R12
         if (lock_det_dis || m_busy) begin
            m_run <= 0; m_lock <= 0;
         end else if (pd_valid) begin
            if (!pd_in_phase) begin
               m_run <= 0; m_lock <= 0;
            end else if (m_run + 1 >= thr_of(lock_sel)) begin
               m_lock <= 1;
            end else begin
               m_run <= m_run + 1;
            end
         end
         // R5
         if (m_acc + longint'(period_fs) >= longint'(TB_TICK)) begin
            m_tick <= 1; m_acc <= m_acc + longint'(period_fs) - longint'(TB_TICK);
         end else begin
            m_tick <= 0; m_acc <= m_acc + longint'(period_fs);
         end
         // R6 to R10
         m_enq <= pll_en; m_msq <= stab_ms;
         if (stab_ms == 0) begin
            m_stab <= 1; m_cnt <= 0;
         end else if (pll_en != m_enq || stab_ms != m_msq || (pll_en && !m_lock)) begin
            m_stab <= 0; m_cnt <= 0;
         end else if (!m_stab && m_tick) begin
            m_cnt <= m_cnt + 1;
            if (m_cnt + 1 == int'(stab_ms)) m_stab <= 1;
         end
         // R11
         m_calq <= cal_bit;
         m_req  <= m_calq && !cal_bit;
         if (m_calq && !cal_bit) m_busy <= 1;
         else if (cal_done) m_busy <= 0;
      end
   end

   task automatic compare();
      chk(pll_locked == m_lock, "R1 R2 R3 R4 R12 pll_locked", pll_locked, m_lock);
      chk(ms_tick == m_tick, "R5 ms_tick", ms_tick, m_tick);
      chk(stable == m_stab, "R6 R7 R8 R9 R10 stable", stable, m_stab);
      chk(cal_req == m_req, "R11 cal_req", cal_req, m_req);
      chk(cal_busy == m_busy, "R11 cal_busy", cal_busy, m_busy);
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog all requirements actual=%0d expected=%0d", cyc, 150000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      rst_n = 0; pd_valid = 0; pd_in_phase = 0; lock_det_dis = 0; lock_sel = 2'd0;
      pll_en = 1; stab_ms = 20'd5; period_fs = 21'd337; cal_bit = 0; cal_done = 0;
      repeat (3) step();
      chk(!pll_locked, "R1 reset", pll_locked, 0);
      chk(!ms_tick, "R5 reset", ms_tick, 0);
      chk(!stable, "R7 reset", stable, 0);
      chk(!cal_req && !cal_busy, "R11 reset", {cal_req, cal_busy}, 0);
      rst_n = 1;

      // R1: exact lock cycle at threshold 128
      pd_valid = 1; pd_in_phase = 1;
      repeat (127) step();
      chk(!pll_locked, "R1 before 128th", pll_locked, 0);
      step();
      chk(pll_locked, "R1 at 128th", pll_locked, 1);
      // R7: stable after 5 ms of lock
      repeat (30) step();
      chk(stable, "R7 stable after interval", stable, 1);
      // R2 and R9
      pd_in_phase = 0; step();
      chk(!pll_locked, "R2 out of phase", pll_locked, 0);
      pd_in_phase = 1; step();
      chk(!stable, "R9 unlock clears stable", stable, 0);

      // R3: each threshold
      for (int s = 1; s < 4; s++) begin
         lock_sel = 2'(s); pd_in_phase = 0; step();
         pd_in_phase = 1;
         repeat (thr_of(2'(s)) - 1) step();
         chk(!pll_locked, "R3 one short", pll_locked, 0);
         step();
         chk(pll_locked, "R3 at threshold", pll_locked, 1);
      end

      // R4
      lock_det_dis = 1; step();
      chk(!pll_locked, "R4 detector off", pll_locked, 0);
      // R6
      stab_ms = 20'd0; step();
      chk(stable, "R6 zero interval", stable, 1);
      // R8 and R10
      pll_en = 0; pd_valid = 0; stab_ms = 20'd4; step();
      chk(!stable, "R10 restart on change", stable, 0);
      repeat (20) step();
      chk(stable, "R8 bypass counts without lock", stable, 1);
      stab_ms = 20'd6; step();
      chk(!stable, "R10 new interval", stable, 0);

      // R11 and R12
      lock_det_dis = 0; pd_valid = 1; pd_in_phase = 1; lock_sel = 2'd0;
      cal_bit = 1; step();
      cal_bit = 0; step();
      chk(cal_req, "R11 request pulse", cal_req, 1);
      step();
      chk(!cal_req && cal_busy, "R11 pulse ends busy stays", {cal_req, cal_busy}, 1);
      repeat (200) step();
      chk(!pll_locked, "R12 hold while busy", pll_locked, 0);
      cal_done = 1; step();
      cal_done = 0;
      chk(!cal_busy, "R11 done clears busy", cal_busy, 0);

      // Random phase
      for (int i = 0; i < 20000; i++) begin
         pd_valid    = ($urandom % 4) != 0;
         pd_in_phase = ($urandom % 300) != 0;
         if ($urandom % 500 == 0) pll_en = ~pll_en;
         if ($urandom % 900 == 0) lock_det_dis = ~lock_det_dis;
         if ($urandom % 700 == 0) lock_sel = 2'($urandom % 4);
         if ($urandom % 400 == 0) stab_ms = 20'($urandom % 6);
         if ($urandom % 600 == 0) cal_bit = ~cal_bit;
         cal_done = ($urandom % 60) == 0;
         step();
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule